// File: doc/BRIEF.md
# Block Edge Classifier

This unit labels one square block of grey-level pixels as an edge block or a flat block. Pixels arrive one per accepted cycle in raster order: row by row, left to right inside each row. For every pixel the unit measures how strongly it differs from its right-hand neighbour and from the pixel directly below it. These two magnitudes are added into a per-pixel edge amplitude, and the amplitudes are summed over the whole block. After the last pixel, the block average is compared with a programmable threshold.

Neighbour access needs no frame memory. A short shift register one block-row deep holds the pixel above. The newest entry of that register is the pixel to the left. Each difference is therefore counted when the later pixel of the pair arrives. A result flag and a one-cycle completion strobe come out one clock after the final pixel. The next block can follow without a gap.

Top module: `edge_block_classifier`

## Requirements
- R1: After reset, `done` and `is_edge` are 0, no pixels of a block have been taken, and the threshold holds `THR_INIT` (16 by default).
- R2: A pixel is taken on each rising clock edge where `pix_valid` is 1. The pixels are in row-major order, and block position k (0..63) is row k/8, column k%8. Cycles with `pix_valid` at 0 change nothing about the block.
- R3: The horizontal term for the pixel at (r,c) is |p(r,c+1) − p(r,c)|. In column 7 it is zero, so no difference is taken across the end of a row.
- R4: The vertical term for the pixel at (r,c) is |p(r+1,c) − p(r,c)|. In row 7 it is zero, so no difference reaches into the next block.
- R5: The block sum is the total of both terms over all 64 pixels. The mean is that sum divided by 64 and rounded down.
- R6: `is_edge` is 1 exactly when the mean is strictly greater than the threshold. A mean equal to the threshold gives 0.
- R7: `done` is 1 for exactly one cycle, on the clock edge after the edge that took the 64th pixel. `is_edge` is 0 whenever `done` is 0.
- R8: `thr_value` is written into the threshold on a rising edge where `thr_load` is 1, no pixel of the current block has been taken and `pix_valid` is 0. In any other case `thr_load` is ignored.
- R9: The sum cannot overflow. A block of alternating 0 and 255 pixels (sum 28560, mean 446) is reported as an edge even with a threshold of 255.
- R10: A difference gives the same magnitude whichever of the two pixels is brighter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_load | input | 1 | Request to write the threshold |
| thr_value | input | 8 | New threshold value |
| pix_valid | input | 1 | `pix_in` carries the next pixel of the block |
| pix_in | input | 8 | Grey-level pixel |
| done | output | 1 | One-cycle strobe: block result ready |
| is_edge | output | 1 | Edge decision, valid only while `done` is 1 |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, an 8×8 block, an 8-bit threshold and the ripple comparator. With these values the largest possible sum, 28560, can be reached with a real alternating pattern, so the top accumulator bits and a 9-bit mean above any 8-bit threshold are exercised. Blocks are sent back to back, so the first row of one block follows the last row of the previous block. This probes the row and block borders. Threshold writes are also attempted at the first pixel and in the middle of a block.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
package ebc_pkg;
   // Result of a magnitude comparison a versus b
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_res_t;
endpackage

// File: rtl/ebc_absdiff.sv
`timescale 1ns/1ps
// Absolute difference from a single adder-subtractor: a + ~b + 1.
// A clear carry-out means a < b, and the result is then re-negated.
module ebc_absdiff #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] mag
);
   logic [W:0]   raw;
   logic         no_borrow;
   logic [W-1:0] low;

   assign raw       = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
   assign no_borrow = raw[W];
   assign low       = raw[W-1:0];
   assign mag       = no_borrow ? low : (~low + W'(1));
endmodule

// File: rtl/ebc_mag_cmp.sv
`timescale 1ns/1ps
// Unsigned magnitude comparator. RIPPLE=1 builds a chain of one-bit cells
// from the most significant bit downwards. RIPPLE=0 uses relational operators.
module ebc_mag_cmp #(
   parameter int W      = 9,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   output ebc_pkg::cmp_res_t res
);
   if (W < 1) begin : g_bad_w
      $error("ebc_mag_cmp: W must be at least 1");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] gt_c;
      logic [W:0] eq_c;
      assign gt_c[W] = 1'b0;
      assign eq_c[W] = 1'b1;
      for (genvar i = W - 1; i >= 0; i--) begin : g_cell
         assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & a[i] & ~b[i]);
         assign eq_c[i] = eq_c[i+1] & ~(a[i] ^ b[i]);
      end
      assign res.gt = gt_c[0];
      assign res.eq = eq_c[0];
      assign res.lt = ~gt_c[0] & ~eq_c[0];
   end else begin : g_flat
      assign res.gt = (a > b);
      assign res.eq = (a == b);
      assign res.lt = (a < b);
   end
endmodule

// File: rtl/ebc_nbr_delay.sv
`timescale 1ns/1ps
// One block-row of pixel history. tap[0] holds the pixel taken just before,
// and tap[ROW_LEN-1] the pixel one row above the current one.
module ebc_nbr_delay #(
   parameter int PIX_W   = 8,
   parameter int ROW_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic [PIX_W-1:0] pix_in,
   output logic [PIX_W-1:0] left_pix,
   output logic [PIX_W-1:0] up_pix
);
   if (ROW_LEN < 2) begin : g_bad_len
      $error("ebc_nbr_delay: ROW_LEN must be at least 2");
   end

   logic [PIX_W-1:0] tap [ROW_LEN];

   for (genvar i = 0; i < ROW_LEN; i++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tap[i] <= '0;
         end else if (shift_en) begin
            if (i == 0) tap[i] <= pix_in;
            else        tap[i] <= tap[(i == 0) ? 0 : i - 1];
         end
      end
   end

   assign left_pix = tap[0];
   assign up_pix   = tap[ROW_LEN-1];
endmodule

// File: rtl/edge_block_classifier.sv
`timescale 1ns/1ps
module edge_block_classifier #(
   parameter int          PIX_W      = 8,
   parameter int          BLK_DIM    = 8,
   parameter int          THR_W      = 8,
   parameter int unsigned THR_INIT   = 16,
   parameter bit          CMP_RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_load,
   input  logic [THR_W-1:0] thr_value,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_in,
   output logic             done,
   output logic             is_edge
);
   import ebc_pkg::*;

   localparam int SIDE_W = $clog2(BLK_DIM);
   localparam int CNT_W  = 2 * SIDE_W;
   localparam int NPIX   = BLK_DIM * BLK_DIM;
   localparam int AMP_W  = PIX_W + 1;
   localparam int ACC_W  = AMP_W + CNT_W;
   localparam int MEAN_W = ACC_W - CNT_W;
   localparam int CMP_W  = (MEAN_W > THR_W) ? MEAN_W : THR_W;

   // elaboration-time parameter checks
   if (BLK_DIM < 2 || (1 << SIDE_W) != BLK_DIM) begin : g_bad_dim
      $error("edge_block_classifier: BLK_DIM must be a power of two >= 2");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $error("edge_block_classifier: PIX_W must be at least 2");
   end
   if (THR_W < 1 || THR_W > 31 || THR_INIT >= (32'd1 << THR_W)) begin : g_bad_thr
      $error("edge_block_classifier: THR_INIT does not fit in THR_W bits");
   end

   // block position
   logic [CNT_W-1:0]  cnt_q;
   logic [SIDE_W-1:0] col;
   logic [SIDE_W-1:0] row;
   logic              last_pix;

   assign col      = cnt_q[SIDE_W-1:0];
   assign row      = cnt_q[CNT_W-1:SIDE_W];
   assign last_pix = pix_valid && (cnt_q == CNT_W'(NPIX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (pix_valid) cnt_q <= cnt_q + CNT_W'(1);
   end

   // neighbour history
   logic [PIX_W-1:0] left_pix;
   logic [PIX_W-1:0] up_pix;

   ebc_nbr_delay #(.PIX_W(PIX_W), .ROW_LEN(BLK_DIM)) u_nbr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (pix_valid),
      .pix_in   (pix_in),
      .left_pix (left_pix),
      .up_pix   (up_pix)
   );

   // gradient magnitudes, counted when the later pixel of each pair arrives
   logic [PIX_W-1:0] h_mag;
   logic [PIX_W-1:0] v_mag;

   ebc_absdiff #(.W(PIX_W)) u_hdiff (.a(pix_in), .b(left_pix), .mag(h_mag));
   ebc_absdiff #(.W(PIX_W)) u_vdiff (.a(pix_in), .b(up_pix),   .mag(v_mag));

   logic [PIX_W-1:0] h_term;
   logic [PIX_W-1:0] v_term;
   logic [AMP_W-1:0] amp;

   assign h_term = (col != '0) ? h_mag : '0;
   assign v_term = (row != '0) ? v_mag : '0;
   assign amp    = {1'b0, h_term} + {1'b0, v_term};

   // block sum
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;

   assign acc_sum = acc_q + ACC_W'(amp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q <= '0;
      else if (pix_valid) acc_q <= last_pix ? '0 : acc_sum;
   end

   // threshold register, writable only between blocks
   logic [THR_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thr_q <= THR_W'(THR_INIT);
      else if (thr_load && !pix_valid && (cnt_q == '0))
         thr_q <= thr_value;
   end

   // mean versus threshold
   logic [MEAN_W-1:0] mean;
   cmp_res_t          cmp;

   assign mean = acc_sum[ACC_W-1:CNT_W];

   ebc_mag_cmp #(.W(CMP_W), .RIPPLE(CMP_RIPPLE)) u_cmp (
      .a   (CMP_W'(mean)),
      .b   (CMP_W'(thr_q)),
      .res (cmp)
   );

   logic done_q;
   logic edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         done_q <= last_pix;
         edge_q <= last_pix & cmp.gt;
      end
   end

   assign done    = done_q;
   assign is_edge = edge_q;

   // assertions
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(cnt_q));                                   // R2
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last_pix |=> done);                                               // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R7
   AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !is_edge);                                              // R7
   AST_THR_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |=> $stable(thr_q));                                // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !last_pix) |=> (acc_q >= $past(acc_q)));            // R9
endmodule

// File: tb/sim_edge_block_classifier.sv
`timescale 1ns/1ps
module sim_edge_block_classifier;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       thr_load = 1'b0;
   logic [7:0] thr_value = '0;
   logic       pix_valid = 1'b0;
   logic [7:0] pix_in = '0;
   logic       done;
   logic       is_edge;

   always #10 clk = ~clk;

   edge_block_classifier u0 (
      .clk(clk), .rst_n(rst_n), .thr_load(thr_load), .thr_value(thr_value),
      .pix_valid(pix_valid), .pix_in(pix_in), .done(done), .is_edge(is_edge)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    finished = 1'b0;
   string tag = "R1";

   // behavioural model state
   int   m_cnt = 0;
   int   m_thr = 16;
   int   m_blk[64];
   int   src[64];
   logic exp_done = 1'b0;
   logic exp_edge = 1'b0;

   function automatic int absval(input int x);
      return (x < 0) ? -x : x;
   endfunction

   function automatic int block_sum();
      int s = 0;
      for (int r = 0; r < 8; r++) begin
         for (int c = 0; c < 8; c++) begin
            if (c < 7) s += absval(m_blk[r*8+c+1] - m_blk[r*8+c]);
            if (r < 7) s += absval(m_blk[(r+1)*8+c] - m_blk[r*8+c]);
         end
      end
      return s;
   endfunction

   task automatic compare_now();
      vectors++;
      if (done !== exp_done) begin
         miscompares++;
         $display("FAIL R7 [%s] done actual=%b expected=%b", tag, done, exp_done);
      end
      if (is_edge !== exp_edge) begin
         miscompares++;
         $display("FAIL R6 [%s] is_edge actual=%b expected=%b", tag, is_edge, exp_edge);
      end
   endtask

   // one clock: check outputs, drive inputs, advance the model
   task automatic step(input logic v, input int p, input logic ld, input int tv);
      @(negedge clk);
      compare_now();
      pix_valid = v;
      pix_in    = 8'(p);
      thr_load  = ld;
      thr_value = 8'(tv);
      exp_done  = 1'b0;
      exp_edge  = 1'b0;
      if (ld && !v && m_cnt == 0) m_thr = tv;
      if (v) begin
         m_blk[m_cnt] = p;
         m_cnt++;
         if (m_cnt == 64) begin
            exp_done = 1'b1;
            exp_edge = ((block_sum() / 64) > m_thr);
            m_cnt = 0;
         end
      end
   endtask

   task automatic send_block(input bit gaps);
      for (int i = 0; i < 64; i++) begin
         step(1'b1, src[i], 1'b0, 0);
         if (gaps && (i % 5 == 2)) step(1'b0, 0, 1'b0, 0);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0);
   endtask

   task automatic load_thr(input int v);
      step(1'b0, 0, 1'b1, v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      compare_now();                     // R1: reset outputs
      rst_n = 1'b1;
      idle(2);

      // R1 default threshold 16: alternate rows 0/20 give mean 17
      for (int i = 0; i < 64; i++) src[i] = ((i / 8) % 2) * 20;
      send_block(1'b0);
      for (int i = 0; i < 64; i++) src[i] = 100;
      tag = "R5";
      send_block(1'b0);
      idle(2);

      // R3: horizontal ramp, mean 8 without row wrap
      tag = "R3";
      for (int i = 0; i < 64; i++) src[i] = (i % 8) * 10;
      load_thr(7);
      send_block(1'b0);
      idle(1);
      tag = "R6";
      load_thr(8);                       // R6: mean equal to threshold
      send_block(1'b0);
      idle(1);

      // R4 and R10: falling vertical ramp, then a block that differs at the seam
      tag = "R4";
      load_thr(20);
      for (int i = 0; i < 64; i++) src[i] = 255 - (i / 8) * 30;
      send_block(1'b0);
      tag = "R10";
      for (int i = 0; i < 64; i++) src[i] = (i / 8) * 30;
      send_block(1'b0);
      idle(1);

      // R2: stalls inside the block
      tag = "R2";
      for (int i = 0; i < 64; i++) src[i] = (i * 37) % 90;
      load_thr(30);
      send_block(1'b1);
      idle(1);

      // R8: writes while busy or with a pixel are ignored
      tag = "R8";
      load_thr(16);
      for (int i = 0; i < 64; i++) src[i] = ((i / 8) % 2) * 20;
      step(1'b1, src[0], 1'b1, 255);
      for (int i = 1; i < 64; i++) begin
         step(1'b1, src[i], 1'b0, 0);
         if (i == 30) step(1'b0, 0, 1'b1, 255);
      end
      idle(1);
      load_thr(17);
      send_block(1'b0);
      idle(1);

      // R9: largest sum with the largest threshold
      tag = "R9";
      load_thr(255);
      for (int i = 0; i < 64; i++) src[i] = (((i / 8) + (i % 8)) % 2) * 255;
      send_block(1'b0);
      idle(1);

      // R5 and R6: mixed blocks around the threshold
      tag = "R5";
      for (int b = 0; b < 24; b++) begin
         load_thr(int'($urandom_range(0, 60)));
         for (int i = 0; i < 64; i++) src[i] = int'($urandom_range(0, 50 + b * 8));
         send_block(b % 3 == 0);
         if (b % 2 == 0) idle(1);
      end
      idle(3);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired, actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule